// File: doc/BRIEF.md
# Sticky Fault Event Register with Service-Request Sender

This block sits between a power supply controller's clean fault levels and its host link. Seven fault conditions arrive as steady levels. Each one is edge-detected and gated by a software-loaded enable byte. Every enabled fault edge latches a bit in an event byte that stays set until something clears it.

Three command strobes clear the event byte: a read, a clear-status command and a power-up pulse. A device-reset command leaves it untouched. Every enabled fault edge also asks the block to emit a four-byte service-request text on a valid/ready byte stream: the letter `I`, the supply address as two decimal digits, and a carriage return. Requests are raised the same way whatever mode the supply is in, because the block has no mode input at all.

Command-string parsing, the line driver and analog fault detection sit outside. The block only sees decoded one-cycle strobes, the fault levels and a static address.

Top module: `fault_srq_top`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) the enable byte and event byte read 0x00 and `tx_valid` is low.
- R2: A cycle with `en_wr` high loads all of `en_wdata` into the enable byte, which shows on `en_q` from the next cycle.
- R3: Fault input `fault_lvl[k]` maps to register bit k+1. The bits are 1 AC fail, 2 over-temperature, 3 foldback, 4 over-voltage, 5 shut-off, 6 output-off, 7 enable. A 0→1 transition of that input sets the event bit on the next edge, but only when enable bit k+1 is 1.
- R4: An event bit stays set after its fault input returns low, until a clear.
- R5: `evt_q` holds the event byte during the `evt_rd` strobe cycle, and the whole byte is 0x00 from the next cycle.
- R6: `clr_stat` and `pwr_up` each clear the whole event byte. `dev_rst` changes neither the event byte nor the enable byte.
- R7: When a clear strobe and an enabled fault edge fall in the same cycle, the new fault's bit is set after the clear.
- R8: Event bit 0 is spare: it always reads 0 and never causes a request, whatever enable bit 0 holds.
- R9: A request is sent as bytes 0x49, 0x30+tens, 0x30+units, 0x0D, for an address in the range 0 to 99. A byte moves when `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged. `tx_valid` is low for the cycle after a carriage return is accepted.
- R10: A fault held high gives exactly one event and one request, not one per clock.
- R11: Any number of enabled fault edges during a message merge into exactly one further message after it.
- R12: With the enable byte at 0x00, no fault sets an event bit and no request is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_lvl | input | 7 | Fault levels; bit k feeds register bit k+1 |
| en_wr | input | 1 | Enable-byte write strobe |
| en_wdata | input | 8 | Enable byte value |
| evt_rd | input | 1 | Event read strobe (read-to-clear) |
| clr_stat | input | 1 | Clear-status strobe |
| dev_rst | input | 1 | Device reset command strobe (no effect on events) |
| pwr_up | input | 1 | Power-up strobe |
| addr | input | 7 | Supply address, 0 to 99 |
| tx_ready | input | 1 | Byte sink ready |
| en_q | output | 8 | Current enable byte |
| evt_q | output | 8 | Current event byte |
| tx_valid | output | 1 | Message byte valid |
| tx_data | output | 8 | Message byte |

## Verification
Two pairs of functions can fall in one cycle. A clearing strobe can meet a fresh enabled fault edge, and a new request can arrive while a message is still going out. The bench forces both in directed steps. In the first, it pulses `evt_rd` on the same edge that an over-voltage level rises, and expects only that bit to remain. In the second, it stalls `tx_ready` while several faults rise, and expects exactly one extra message. A random phase then mixes all strobes, faults and ready stalls, and a behavioural model judges every output on every clock.

// File: rtl/fault_srq_pkg.sv
package fault_srq_pkg;

    localparam int NFLT    = 7;
    localparam int REG_W   = NFLT + 1;
    localparam int ADDR_W  = 7;
    localparam int BYTE_W  = 8;

    localparam int BIT_SPARE = 0;
    localparam int BIT_AC    = 1;
    localparam int BIT_OTEMP = 2;
    localparam int BIT_FOLD  = 3;
    localparam int BIT_OVOLT = 4;
    localparam int BIT_SHUT  = 5;
    localparam int BIT_OUTOF = 6;
    localparam int BIT_ENA   = 7;

    localparam logic [BYTE_W-1:0] CH_HDR  = 8'h49;
    localparam logic [BYTE_W-1:0] CH_ZERO = 8'h30;
    localparam logic [BYTE_W-1:0] CH_CR   = 8'h0D;

    typedef enum logic [1:0] {
        MSG_HDR  = 2'd0,
        MSG_TENS = 2'd1,
        MSG_ONES = 2'd2,
        MSG_CR   = 2'd3
    } msg_pos_e;

    typedef struct packed {
        logic [BYTE_W-1:0] tens;
        logic [BYTE_W-1:0] ones;
    } addr_txt_t;

    function automatic addr_txt_t addr_to_txt(input logic [ADDR_W-1:0] a);
        addr_txt_t r;
        logic [ADDR_W-1:0] t;
        logic [ADDR_W-1:0] o;
        t = a / ADDR_W'(10);
        o = a - t * ADDR_W'(10);
        r.tens = CH_ZERO + BYTE_W'(t);
        r.ones = CH_ZERO + BYTE_W'(o);
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] msg_byte(input msg_pos_e p, input addr_txt_t x);
        case (p)
            MSG_HDR:  return CH_HDR;
            MSG_TENS: return x.tens;
            MSG_ONES: return x.ones;
            default:  return CH_CR;
        endcase
    endfunction

endpackage

// File: rtl/fault_evt_reg.sv
module fault_evt_reg
    import fault_srq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLT-1:0]  fault_lvl,
    input  logic             en_wr,
    input  logic [REG_W-1:0] en_wdata,
    input  logic             clr_any,
    output logic [REG_W-1:0] en_q,
    output logic [REG_W-1:0] evt_q,
    output logic             trig
);

    logic [NFLT-1:0]  lvl_d;
    logic [NFLT-1:0]  rise;
    logic [NFLT-1:0]  hit;
    logic [REG_W-1:0] new_bits;
    logic [REG_W-1:0] evt_nx;

    always_comb begin
        rise     = fault_lvl & ~lvl_d;
        hit      = rise & en_q[REG_W-1:1];
        new_bits = {hit, 1'b0};
        evt_nx   = (clr_any ? '0 : evt_q) | new_bits;
        trig     = |hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_d <= '0;
            en_q  <= '0;
            evt_q <= '0;
        end else begin
            lvl_d <= fault_lvl;
            evt_q <= evt_nx;
            if (en_wr) en_q <= en_wdata;
        end
    end

    // R8: spare bit never latches
    a_r8_spare_zero: assert property (@(posedge clk) disable iff (rst)
        evt_q[BIT_SPARE] == 1'b0);

    // R4: without a clear, no set bit is ever dropped
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr_any |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

    // R5: a clear with no fresh fault empties the byte
    a_r5_clear_all: assert property (@(posedge clk) disable iff (rst)
        (clr_any && hit == '0) |=> evt_q == '0);

    // R12: a zero mask means nothing new appears
    a_r12_mask_zero: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |=> ((evt_q & ~$past(evt_q)) == '0));

endmodule

// File: rtl/srq_msg_tx.sv
module srq_msg_tx
    import fault_srq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic [ADDR_W-1:0] addr,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data
);

    logic      busy;
    logic      pend;
    msg_pos_e  pos;
    addr_txt_t txt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            pend  <= 1'b0;
            pos   <= MSG_HDR;
            txt_q <= '0;
        end else if (!busy) begin
            if (pend) begin
                busy  <= 1'b1;
                pos   <= MSG_HDR;
                txt_q <= addr_to_txt(addr);
                pend  <= trig;
            end else begin
                pend  <= trig;
            end
        end else begin
            pend <= pend | trig;
            if (tx_ready) begin
                if (pos == MSG_CR) busy <= 1'b0;
                else               pos  <= msg_pos_e'(pos + 2'd1);
            end
        end
    end

    always_comb begin
        tx_valid = busy;
        tx_data  = msg_byte(pos, txt_q);
    end

    // R9: stalled byte is held
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R9: a gap follows the accepted carriage return
    a_r9_gap_after_cr: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_data == CH_CR) |=> !tx_valid);

    // R9: every message opens with the header byte
    a_r9_hdr_first: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> tx_data == CH_HDR);

endmodule

// File: rtl/fault_srq_top.sv
module fault_srq_top
    import fault_srq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NFLT-1:0]   fault_lvl,
    input  logic              en_wr,
    input  logic [REG_W-1:0]  en_wdata,
    input  logic              evt_rd,
    input  logic              clr_stat,
    input  logic              dev_rst,
    input  logic              pwr_up,
    input  logic [ADDR_W-1:0] addr,
    input  logic              tx_ready,
    output logic [REG_W-1:0]  en_q,
    output logic [REG_W-1:0]  evt_q,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data
);

    logic clr_any;
    logic trig;

    assign clr_any = evt_rd | clr_stat | pwr_up;

    fault_evt_reg u_evt (
        .clk      (clk),
        .rst      (rst),
        .fault_lvl(fault_lvl),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .clr_any  (clr_any),
        .en_q     (en_q),
        .evt_q    (evt_q),
        .trig     (trig)
    );

    srq_msg_tx u_tx (
        .clk     (clk),
        .rst     (rst),
        .trig    (trig),
        .addr    (addr),
        .tx_ready(tx_ready),
        .tx_valid(tx_valid),
        .tx_data (tx_data)
    );

    // R6: a lone device reset keeps every event bit
    a_r6_devrst_keep: assert property (@(posedge clk) disable iff (rst)
        (dev_rst && !clr_any) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

    // R6: a lone device reset keeps the enable byte
    a_r6_devrst_en: assert property (@(posedge clk) disable iff (rst)
        (dev_rst && !en_wr) |=> $stable(en_q));

    // R2: no write, no enable change
    a_r2_en_stable: assert property (@(posedge clk) disable iff (rst)
        !en_wr |=> $stable(en_q));

endmodule

// File: tb/fault_srq_top_test.sv
module fault_srq_top_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [6:0] fault_lvl;
    logic       en_wr;
    logic [7:0] en_wdata;
    logic       evt_rd, clr_stat, dev_rst, pwr_up;
    logic [6:0] addr;
    logic       tx_ready;
    logic [7:0] en_q, evt_q, tx_data;
    logic       tx_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    fault_srq_top uut (
        .clk(clk), .rst(rst), .fault_lvl(fault_lvl), .en_wr(en_wr),
        .en_wdata(en_wdata), .evt_rd(evt_rd), .clr_stat(clr_stat),
        .dev_rst(dev_rst), .pwr_up(pwr_up), .addr(addr), .tx_ready(tx_ready),
        .en_q(en_q), .evt_q(evt_q), .tx_valid(tx_valid), .tx_data(tx_data)
    );

    // behavioural reference
    logic [7:0] m_en, m_evt;
    logic [6:0] m_prev;
    bit         m_busy, m_pend;
    int         m_pos;
    int         m_addr;
    byte        got[$];

    function automatic logic [7:0] exp_byte(int p, int a);
        case (p)
            0: return 8'h49;
            1: return 8'(8'h30 + a / 10);
            2: return 8'(8'h30 + a % 10);
            default: return 8'h0D;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        logic [6:0] hit;
        bit trig;
        if (rst) begin
            m_en = 0; m_evt = 0; m_prev = 0;
            m_busy = 0; m_pend = 0; m_pos = 0; m_addr = 0;
        end else begin
            hit  = fault_lvl & ~m_prev & m_en[7:1];
            trig = (hit != 0);
            if (m_busy && tx_ready) got.push_back(exp_byte(m_pos, m_addr));
            if (!m_busy) begin
                if (m_pend) begin m_busy = 1; m_pos = 0; m_addr = addr; end
                m_pend = trig;
            end else begin
                m_pend = m_pend | trig;
                if (tx_ready) begin
                    if (m_pos == 3) m_busy = 0; else m_pos++;
                end
            end
            m_evt = ((evt_rd || clr_stat || pwr_up) ? 8'h00 : m_evt) | {hit, 1'b0};
            if (en_wr) m_en = en_wdata;
            m_prev = fault_lvl;
        end
    end

    // cycle-by-cycle comparison
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            chk(evt_q == m_evt, "R3 evt_q", evt_q, m_evt);
            chk(en_q == m_en, "R2 en_q", en_q, m_en);
            chk(tx_valid == m_busy, "R9 tx_valid", tx_valid, m_busy);
            if (m_busy)
                chk(tx_data == exp_byte(m_pos, m_addr), "R9 tx_data", tx_data, exp_byte(m_pos, m_addr));
        end
    end

    task automatic idle_in;
        en_wr = 0; evt_rd = 0; clr_stat = 0; dev_rst = 0; pwr_up = 0;
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle;
        @(posedge clk); #3;
    endtask

    function automatic int count_msgs();
        int c = 0;
        foreach (got[i]) if (got[i] == 8'h0D) c++;
        return c;
    endfunction

    initial begin
        #1_500_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int m0;
        rst = 1; fault_lvl = 0; en_wdata = 0; addr = 7'd7; tx_ready = 1;
        idle_in();
        cyc(3);
        rst = 0;
        settle();
        chk(en_q == 0 && evt_q == 0 && !tx_valid, "R1 reset state", {en_q, evt_q}, 0);

        // R2: enable load
        @(negedge clk); en_wr = 1; en_wdata = 8'hFF;
        @(negedge clk); idle_in();
        chk(en_q == 8'hFF, "R2 enable load", en_q, 8'hFF);

        // R3/R9/R10: AC fail held for a long time
        got.delete();
        @(negedge clk); fault_lvl = 7'b0000001;
        cyc(30);
        chk(evt_q == 8'h02, "R3 AC bit", evt_q, 8'h02);
        chk(count_msgs() == 1, "R10 one request", count_msgs(), 1);
        chk(got.size() == 4 && got[0] == 8'h49 && got[1] == 8'h30 && got[2] == 8'h37 && got[3] == 8'h0D,
            "R9 message I07 CR", got.size(), 4);

        // R4: sticky
        fault_lvl = 0; cyc(5);
        chk(evt_q == 8'h02, "R4 sticky", evt_q, 8'h02);

        // R6: device reset keeps events and enable
        dev_rst = 1; @(negedge clk); idle_in();
        chk(evt_q == 8'h02 && en_q == 8'hFF, "R6 dev_rst keeps", evt_q, 8'h02);

        // R5: read to clear
        evt_rd = 1; #1;
        chk(evt_q == 8'h02, "R5 read value", evt_q, 8'h02);
        @(negedge clk); idle_in();
        chk(evt_q == 8'h00, "R5 cleared after read", evt_q, 0);

        // R6: clear-status and power-up
        fault_lvl = 7'b0000010; cyc(10); fault_lvl = 0;
        clr_stat = 1; @(negedge clk); idle_in();
        chk(evt_q == 0, "R6 clr_stat clears", evt_q, 0);
        fault_lvl = 7'b0100000; cyc(10); fault_lvl = 0;
        pwr_up = 1; @(negedge clk); idle_in();
        chk(evt_q == 0, "R6 pwr_up clears", evt_q, 0);

        // R7: read and new over-voltage edge in one cycle
        fault_lvl = 7'b0000001; cyc(10);
        evt_rd = 1; fault_lvl = 7'b0001001;
        @(negedge clk); idle_in();
        chk(evt_q == 8'h10, "R7 new edge survives clear", evt_q, 8'h10);
        fault_lvl = 0; cyc(12);

        // R11: stall and stack several faults during one message
        addr = 7'd42; got.delete(); tx_ready = 0;
        fault_lvl = 7'b0000001; cyc(3);
        fault_lvl = 7'b0000011; cyc(1);
        fault_lvl = 7'b0000111; cyc(1);
        fault_lvl = 7'b0001111; cyc(2);
        tx_ready = 1; cyc(30);
        chk(count_msgs() == 2, "R11 merged requests", count_msgs(), 2);
        chk(got.size() == 8 && got[5] == 8'h34 && got[6] == 8'h32, "R9 address 42", got.size(), 8);
        fault_lvl = 0; clr_stat = 1; @(negedge clk); idle_in();

        // R12: zero mask
        en_wr = 1; en_wdata = 8'h00; @(negedge clk); idle_in();
        got.delete();
        fault_lvl = 7'h7F; cyc(15);
        chk(evt_q == 0, "R12 no events", evt_q, 0);
        chk(got.size() == 0 && !tx_valid, "R12 no request", got.size(), 0);
        fault_lvl = 0; cyc(2);

        // R8: spare bit only enabled
        en_wr = 1; en_wdata = 8'h01; @(negedge clk); idle_in();
        fault_lvl = 7'h7F; cyc(15);
        chk(evt_q[0] == 0 && got.size() == 0, "R8 spare inert", evt_q, 0);
        fault_lvl = 0; cyc(2);

        // random mix, address 99 then 0
        addr = 7'd99;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            fault_lvl = 7'($urandom);
            tx_ready  = ($urandom % 3) != 0;
            en_wr     = ($urandom % 40) == 0;
            en_wdata  = 8'($urandom);
            evt_rd    = ($urandom % 9) == 0;
            clr_stat  = ($urandom % 25) == 0;
            dev_rst   = ($urandom % 11) == 0;
            pwr_up    = ($urandom % 50) == 0;
            if (i == 1500) addr = 7'd0;
        end
        @(negedge clk); idle_in(); fault_lvl = 0; tx_ready = 1;
        m0 = count_msgs();
        cyc(40);
        chk(!tx_valid && count_msgs() >= m0, "R11 drains after random", tx_valid, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule